// File: doc/BRIEF.md
# Register Write-Unlock Sequencer

This block sits behind a serial-bus transaction decoder and guards a small clock and control register space. The decoder hands it one event per beat: a start, a byte, a stop, or an abort for a malformed bit count. The block follows the transaction (device byte, address, data bytes) and forwards accepted data bytes to the register file as a one-cycle write strobe with address and data.

Two volatile latches gate those writes: a write-enable latch and a register-write-enable latch. Software sets them by writing magic codes to the status register, which always accepts writes. A clock or control write goes through only while both latches are set. A completed write of that kind consumes the register-write-enable latch. A write that reaches the non-volatile control bytes also opens a busy window. The window lasts a parameterised number of timebase ticks, and new write transactions are ignored until it closes.

The address map, fixed in the package, is as follows. Clock bytes sit at 30h–37h. Control bytes sit at 10h–14h and are non-volatile. The status register sits at 3Fh. The write device byte is DEh and the read device byte is DFh.

Top module: `reg_unlock_seq`

## Requirements
- R1: After reset, wel, rwel, busy and wr_valid are all 0, and ev_ready is 1 from the first clock after reset onwards.
- R2: A completed write of 02h to the status register (3Fh) sets wel and leaves rwel unchanged.
- R3: A completed write of 06h to the status register sets both wel and rwel, and rwel is never 1 while wel is 0.
- R4: A completed status write of 00h clears both latches, and any other status value leaves both latches unchanged.
- R5: A data byte aimed at the clock (30h–37h) or control (10h–14h) bytes is forwarded on wr_valid/wr_addr/wr_data one cycle after it is accepted, and only if wel and rwel are both 1 at that time. Otherwise it is dropped.
- R6: Within a write, the address increments once per data byte. A byte is forwarded or applied only while its address lies in the same region as the starting address. Bytes to undefined addresses, or past the end of the region, have no effect.
- R7: A stop that ends a write in which at least one byte was forwarded clears rwel and keeps wel.
- R8: A write ended by an abort event, or cut short by a new start, leaves rwel set.
- R9: Read transactions (device byte DFh) change neither latch and forward nothing.
- R10: A completed write that forwarded control bytes raises busy for exactly NV_TICKS tick pulses. A completed clock-byte write does not raise busy.
- R11: While busy is 1, a write transaction is ignored entirely, including any status byte it carries.
- R12: A status byte takes effect only at the stop of its transaction, so an aborted status write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event beat valid |
| ev_ready | output | 1 | Event beat ready; held at 1 after reset, so there is no back-pressure and a beat transfers on every cycle ev_valid is 1 |
| ev_kind | input | 2 | 0 start, 1 byte, 2 stop, 3 abort |
| ev_data | input | 8 | Byte value for byte events |
| tick | input | 1 | One-cycle timebase pulse for the busy window |
| wr_valid | output | 1 | One-cycle write strobe; the consumer has no ready and must take every strobe |
| wr_addr | output | 8 | Register address of the strobe |
| wr_data | output | 8 | Register data of the strobe |
| wel | output | 1 | Write-enable latch |
| rwel | output | 1 | Register-write-enable latch |
| busy | output | 1 | Non-volatile write window in progress |

## Verification
The bench builds the block with NV_TICKS set to 4 instead of the default 20. This lets a random run open and close many busy windows and lets directed cases count the exact tick that releases busy. The address map stays at its defaults, so random start addresses near each region's end reach the region-crossing cut-off. Random status codes exercise both the magic values and the ignored values.

// File: rtl/rus_pkg.sv
package rus_pkg;
  typedef enum logic [1:0] {EV_START = 2'd0, EV_BYTE = 2'd1, EV_STOP = 2'd2, EV_ABORT = 2'd3} ev_kind_t;
  typedef enum logic [1:0] {RG_NONE = 2'd0, RG_CLK = 2'd1, RG_STAT = 2'd2, RG_CTL = 2'd3} region_t;
  localparam int unsigned AW        = 8;
  localparam int unsigned DW        = 8;
  localparam logic [DW-1:0] DEV_WR  = 8'hDE;
  localparam logic [AW-1:0] CLK_BASE = 8'h30;
  localparam int unsigned  CLK_SIZE = 8;
  localparam logic [AW-1:0] CTL_BASE = 8'h10;
  localparam int unsigned  CTL_SIZE = 5;
  localparam logic [AW-1:0] STAT_ADDR = 8'h3F;
  localparam logic [DW-1:0] CODE_CLR = 8'h00;
  localparam logic [DW-1:0] CODE_WEL = 8'h02;
  localparam logic [DW-1:0] CODE_ALL = 8'h06;
endpackage

// File: rtl/rus_addr_region.sv
module rus_addr_region
  import rus_pkg::*;
(
  input  logic [AW-1:0] addr,
  output region_t       rg
);
  localparam logic [AW-1:0] CLK_LAST = CLK_BASE + AW'(CLK_SIZE - 1);
  localparam logic [AW-1:0] CTL_LAST = CTL_BASE + AW'(CTL_SIZE - 1);

  always_comb begin
    if (addr >= CLK_BASE && addr <= CLK_LAST)      rg = RG_CLK;
    else if (addr >= CTL_BASE && addr <= CTL_LAST) rg = RG_CTL;
    else if (addr == STAT_ADDR)                    rg = RG_STAT;
    else                                           rg = RG_NONE;
  end
endmodule

// File: rtl/rus_latches.sv
module rus_latches
  import rus_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          apply,
  input  logic [DW-1:0] code,
  input  logic          consume,
  output logic          wel,
  output logic          rwel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel  <= 1'b0;
      rwel <= 1'b0;
    end else if (apply) begin
      case (code)
        CODE_CLR: begin wel <= 1'b0; rwel <= 1'b0; end
        CODE_WEL: wel <= 1'b1;
        CODE_ALL: begin wel <= 1'b1; rwel <= 1'b1; end
        default: ;
      endcase
    end else if (consume) begin
      rwel <= 1'b0;
    end
  end
endmodule

// File: rtl/rus_busy_timer.sv
module rus_busy_timer #(
  parameter int unsigned TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic busy
);
  localparam int unsigned CW = $clog2(TICKS + 1);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 remain <= '0;
    else if (start)             remain <= CW'(TICKS);
    else if (tick && remain != '0) remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/reg_unlock_seq.sv
module reg_unlock_seq
  import rus_pkg::*;
#(
  parameter int unsigned NV_TICKS = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  output logic          ev_ready,
  input  logic [1:0]    ev_kind,
  input  logic [DW-1:0] ev_data,
  input  logic          tick,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wel,
  output logic          rwel,
  output logic          busy
);
  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_ADDR, ST_DATA, ST_SKIP} st_t;

  st_t           state;
  logic [AW-1:0] cur_addr;
  region_t       txn_rg, cur_rg, new_rg;
  logic          wrote_any, stat_pend;
  logic [DW-1:0] stat_code;
  logic          acc, stop_fire, apply, consume, nv_start;
  ev_kind_t      kind;

  assign kind = ev_kind_t'(ev_kind);
  assign acc  = ev_valid && ev_ready;

  rus_addr_region u_rg_cur (.addr(cur_addr), .rg(cur_rg));
  rus_addr_region u_rg_new (.addr(ev_data),  .rg(new_rg));

  assign stop_fire = acc && kind == EV_STOP && state == ST_DATA;
  assign apply     = stop_fire && stat_pend;
  assign consume   = stop_fire && wrote_any;
  assign nv_start  = consume && txn_rg == RG_CTL;

  rus_latches u_lat (
    .clk(clk), .rst_n(rst_n), .apply(apply), .code(stat_code),
    .consume(consume), .wel(wel), .rwel(rwel)
  );

  rus_busy_timer #(.TICKS(NV_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(nv_start), .tick(tick), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_ready <= 1'b0;
    else        ev_ready <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_addr  <= '0;
      txn_rg    <= RG_NONE;
      wrote_any <= 1'b0;
      stat_pend <= 1'b0;
      stat_code <= '0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (acc) begin
        case (kind)
          EV_START: begin
            state     <= ST_DEV;
            wrote_any <= 1'b0;
            stat_pend <= 1'b0;
          end
          EV_STOP, EV_ABORT: begin
            state     <= ST_IDLE;
            wrote_any <= 1'b0;
            stat_pend <= 1'b0;
          end
          default: begin
            case (state)
              ST_DEV:  state <= (ev_data == DEV_WR && !busy) ? ST_ADDR : ST_SKIP;
              ST_ADDR: begin
                cur_addr <= ev_data;
                txn_rg   <= new_rg;
                state    <= ST_DATA;
              end
              ST_DATA: begin
                cur_addr <= cur_addr + 1'b1;
                if (cur_rg == txn_rg && txn_rg != RG_NONE) begin
                  if (txn_rg == RG_STAT) begin
                    stat_pend <= 1'b1;
                    stat_code <= ev_data;
                  end else if (wel && rwel) begin
                    wr_valid  <= 1'b1;
                    wr_addr   <= cur_addr;
                    wr_data   <= ev_data;
                    wrote_any <= 1'b1;
                  end
                end
              end
              default: ;
            endcase
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/reg_unlock_seq_chk.sv
module reg_unlock_seq_chk
  import rus_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic          wel,
  input logic          rwel,
  input logic          busy
);
  assert_fwd_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(wel && rwel));

  assert_rwel_implies_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rwel |-> wel);

  assert_fwd_in_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ((wr_addr >= CLK_BASE && wr_addr < CLK_BASE + AW'(CLK_SIZE)) ||
                  (wr_addr >= CTL_BASE && wr_addr < CTL_BASE + AW'(CTL_SIZE))));

  assert_busy_needs_unlock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(rwel) && !rwel));

  assert_no_fwd_when_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !$past(busy));
endmodule

bind reg_unlock_seq reg_unlock_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wel(wel), .rwel(rwel), .busy(busy)
);

// File: tb/sim_reg_unlock_seq.sv
module sim_reg_unlock_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;

  logic clk = 0, rst_n = 0, ev_valid = 0, tick = 0;
  logic [1:0] ev_kind = 0;
  logic [7:0] ev_data = 0;
  logic ev_ready, wr_valid, wel, rwel, busy;
  logic [7:0] wr_addr, wr_data;

  int tests = 0, fails = 0;
  int emit_n = 0, emit_sum = 0;
  bit m_wel = 0, m_rwel = 0;
  int m_bt = 0;
  bit done = 0;

  reg_unlock_seq #(.NV_TICKS(NV)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_data(ev_data), .tick(tick), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wel(wel), .rwel(rwel), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (wr_valid) begin
    emit_n++;
    emit_sum += int'({wr_addr, wr_data});
  end

  function automatic int rg(input logic [7:0] a);
    if (a >= 8'h30 && a <= 8'h37) return 1;
    if (a == 8'h3F) return 2;
    if (a >= 8'h10 && a <= 8'h14) return 3;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ev(input logic [1:0] k, input logic [7:0] d);
    @(negedge clk);
    ev_valid = 1; ev_kind = k; ev_data = d;
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic check_state(input string req);
    chk(wel == m_wel, {req, " wel"}, wel, m_wel);
    chk(rwel == m_rwel, {req, " rwel"}, rwel, m_rwel);
    chk(busy == (m_bt != 0), {req, " busy"}, busy, m_bt != 0);
  endtask

  // write transaction; abort: 0 stop, 1 abort event, 2 new start
  task automatic wtxn(input logic [7:0] addr, input int n, input logic [7:0] d0,
                      input int abort, input string req);
    int en = 0, es = 0, n0 = emit_n, s0 = emit_sum;
    bit pend = 0, any = 0, active = (m_bt == 0);
    logic [7:0] code = 0;
    ev(2'd0, 8'h00); ev(2'd1, 8'hDE); ev(2'd1, addr);
    for (int i = 0; i < n; i++) begin
      logic [7:0] a = addr + 8'(i);
      logic [7:0] d = d0 + 8'(i);
      ev(2'd1, d);
      if (active && rg(a) == rg(addr) && rg(addr) != 0) begin
        if (rg(addr) == 2) begin pend = 1; code = d; end
        else if (m_wel && m_rwel) begin en++; es += int'({a, d}); any = 1; end
      end
    end
    if (abort == 0) ev(2'd2, 8'h00);
    else if (abort == 1) ev(2'd3, 8'h00);
    else begin ev(2'd0, 8'h00); ev(2'd2, 8'h00); end
    if (abort == 0) begin
      if (pend) begin
        if (code == 8'h00) begin m_wel = 0; m_rwel = 0; end
        else if (code == 8'h02) m_wel = 1;
        else if (code == 8'h06) begin m_wel = 1; m_rwel = 1; end
      end
      if (any) begin
        m_rwel = 0;
        if (rg(addr) == 3) m_bt = NV;
      end
    end
    chk(emit_n - n0 == en, {req, " count"}, emit_n - n0, en);
    chk(emit_sum - s0 == es, {req, " data"}, emit_sum - s0, es);
    check_state(req);
  endtask

  task automatic rtxn(input logic [7:0] addr, input string req);
    int n0 = emit_n;
    ev(2'd0, 8'h00); ev(2'd1, 8'hDF); ev(2'd1, addr); ev(2'd1, 8'h06); ev(2'd2, 8'h00);
    chk(emit_n == n0, {req, " read fwd"}, emit_n - n0, 0);
    check_state(req);
  endtask

  task automatic tk(input string req);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    if (m_bt > 0) m_bt--;
    chk(busy == (m_bt != 0), {req, " busy after tick"}, busy, m_bt != 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); @(negedge clk);
    chk(ev_ready == 1, "R1 ready", ev_ready, 1);
    chk(wr_valid == 0, "R1 wr_valid", wr_valid, 0);
    check_state("R1");

    wtxn(8'h30, 8, 8'h11, 0, "R5 locked clock write");
    wtxn(8'h3F, 1, 8'h02, 0, "R2 set wel");
    wtxn(8'h30, 2, 8'h21, 0, "R5 wel only");
    wtxn(8'h3F, 1, 8'h06, 0, "R3 set both");
    wtxn(8'h30, 8, 8'h40, 0, "R7 full clock write");
    wtxn(8'h3F, 1, 8'h06, 0, "R3 set again");
    wtxn(8'h35, 5, 8'h50, 0, "R6 crosses region end");
    wtxn(8'h3F, 1, 8'h06, 0, "R3 set");
    wtxn(8'h50, 3, 8'h60, 0, "R6 undefined address");
    wtxn(8'h31, 2, 8'h70, 1, "R8 abort keeps rwel");
    wtxn(8'h32, 2, 8'h78, 2, "R8 restart keeps rwel");
    rtxn(8'h3F, "R9 read between steps");
    wtxn(8'h10, 6, 8'h80, 0, "R10 control write");
    for (int i = 0; i < NV - 1; i++) tk("R10 window");
    wtxn(8'h3F, 1, 8'h00, 0, "R11 status ignored while busy");
    wtxn(8'h3F, 1, 8'h06, 0, "R11 unlock ignored while busy");
    tk("R10 release");
    wtxn(8'h3F, 1, 8'h07, 0, "R4 other code");
    wtxn(8'h3F, 1, 8'h00, 0, "R4 clear");
    wtxn(8'h3F, 1, 8'h06, 1, "R12 aborted status");
    wtxn(8'h3F, 2, 8'h06, 0, "R6 status overrun");

    for (int k = 0; k < 400; k++) begin
      int c = int'($urandom % 7);
      int ab = ($urandom % 5 == 0) ? int'($urandom % 3) : 0;
      case (c)
        0, 1: begin
          logic [7:0] code;
          int p = int'($urandom % 4);
          code = (p == 0) ? 8'h00 : (p == 1) ? 8'h02 : (p == 2) ? 8'h06 : 8'($urandom);
          wtxn(8'h3F, 1, code, ab, "R4 random status");
        end
        2: wtxn(8'h30 + 8'($urandom % 10), 1 + int'($urandom % 9), 8'($urandom), ab, "R6 random clock");
        3: wtxn(8'h10 + 8'($urandom % 7), 1 + int'($urandom % 6), 8'($urandom), ab, "R10 random control");
        4: rtxn(8'($urandom), "R9 random read");
        5: tk("R10 random tick");
        default: wtxn(8'h40 + 8'($urandom % 32), 1 + int'($urandom % 3), 8'($urandom), ab, "R6 random undefined");
      endcase
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule